// File: doc/BRIEF.md
# Interrupt Cause and Mask Unit

This block collects interrupt causes from the event sources of a peripheral expansion controller and raises one interrupt request toward the host. Each source raises an event that carries a set of cause bits and a delivery delay. The cause bits are latched at once and stay set. A notification pulse reaches the host only after the programmed number of cycles.

The host can read the cause and mask registers, and it writes the mask. Changing the mask sends a fresh notification when pending causes are covered by the old or the new mask. A byte-wide write to the status location overwrites the cause register. This is how the host clears causes it has serviced.

The block gives two outputs. `irq_level` is a continuous level. `irq_pulse` is a one-clock notification strobe for an interrupt controller that works on edges.

Top module: `intr_gate`

## Requirements
- R1: A cycle with `evt_valid` high ORs `evt_bits` into the cause register at that clock edge. An event never clears a cause bit that is already set.
- R2: `irq_level` is high exactly when the bitwise AND of the cause and mask registers is nonzero.
- R3: A word write to the mask (`wr_en`=1, `wr_byte`=0, `wr_sel`=1) loads `wr_data` into the mask at the edge. In the following cycle `irq_pulse` is high if the written value differs from the old mask and (old mask OR new value) AND cause, with cause taken before that edge, is nonzero.
- R4: A byte write to the status location (`wr_en`=1, `wr_byte`=1, `wr_sel`=0) replaces the cause register with `wr_data[7:0]` zero-extended. An event in the same cycle ORs its bits on top of the written value.
- R5: An event with no delivery pending makes `irq_pulse` high for one cycle after the max(`evt_delay`,1)-th edge that follows the event's edge. A delay of 0 behaves like 1.
- R6: If an event arrives while a delivery is pending, the pending delivery moves to the earlier of its own due edge and the new event's due edge. If the pending delivery is due at that very edge, it fires and the new event schedules nothing further.
- R7: A word write to the status location, and a byte write to the mask location, change neither register.
- R8: After reset, cause and mask are zero, both interrupt outputs are low and no delivery is pending.
- R9: `rd_data` shows the cause register when `rd_sel`=0 and the mask register when `rd_sel`=1, combinationally. `irq_pulse` is one cycle wide per edge, even when a mask notification and a timed delivery coincide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Event raised this cycle |
| evt_bits | input | 16 | Cause bits carried by the event |
| evt_delay | input | 8 | Delivery delay in cycles (0 treated as 1) |
| wr_en | input | 1 | Host write strobe |
| wr_byte | input | 1 | 1 = byte-wide write, 0 = word-wide write |
| wr_sel | input | 1 | Write target: 0 = status/cause, 1 = mask |
| wr_data | input | 16 | Host write data |
| rd_sel | input | 1 | Read target: 0 = cause, 1 = mask |
| rd_data | output | 16 | Selected register value |
| irq_level | output | 1 | Level request, any unmasked cause |
| irq_pulse | output | 1 | One-cycle notification strobe |

## Verification
The bound assertions check the following on every cycle:
- events never clear cause bits;
- mask words and status bytes land as written;
- writes of the wrong width leave both registers untouched;
- a fresh event cannot notify at its own edge;
- a due counter always fires;
- a reload during a pending delivery only shortens the wait.

Only the bench's scenarios can show the exact delivery cycle against a reference that tracks absolute due times. The same applies to the moved-earlier and fire-at-the-event-edge cases of overlapping events, the old-or-new-mask coverage rule with its same-value exception, and the merging of coinciding notifications.

// File: rtl/intr_gate.sv
module intr_gate #(
  parameter int W      = 16,
  parameter int DLY_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [W-1:0]     evt_bits,
  input  logic [DLY_W-1:0] evt_delay,
  input  logic             wr_en,
  input  logic             wr_byte,
  input  logic             wr_sel,
  input  logic [W-1:0]     wr_data,
  input  logic             rd_sel,
  output logic [W-1:0]     rd_data,
  output logic             irq_level,
  output logic             irq_pulse
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [W-1:0]     cause_q, mask_q, cause_d;
  logic [DLY_W-1:0] cnt_q, dly_eff, left, dly_new;
  logic             pend_q, pulse_q;

  wire byte_st   = wr_en & wr_byte & ~wr_sel;
  wire mask_wr   = wr_en & ~wr_byte & wr_sel;
  wire mask_note = mask_wr && (wr_data != mask_q) && (|((mask_q | wr_data) & cause_q));
  wire fire      = pend_q && (cnt_q == ONE);

  assign dly_eff = (evt_delay == '0) ? ONE : evt_delay;
  assign left    = cnt_q - ONE;
  assign dly_new = (pend_q && (left < dly_eff)) ? left : dly_eff;
  assign cause_d = (byte_st ? {{(W-BYTE_W){1'b0}}, wr_data[BYTE_W-1:0]} : cause_q)
                 | (evt_valid ? evt_bits : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      mask_q  <= '0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cause_q <= cause_d;
      if (mask_wr) mask_q <= wr_data;
      pulse_q <= fire | mask_note;
      if (fire) begin
        pend_q <= 1'b0;
      end else if (evt_valid) begin
        pend_q <= 1'b1;
        cnt_q  <= dly_new;
      end else if (pend_q) begin
        cnt_q  <= left;
      end
    end
  end

  assign irq_level = |(cause_q & mask_q);
  assign irq_pulse = pulse_q;
  assign rd_data   = rd_sel ? mask_q : cause_q;
endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk #(
  parameter int W      = 16,
  parameter int DLY_W  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             evt_valid,
  input logic [W-1:0]     evt_bits,
  input logic             wr_en,
  input logic             wr_byte,
  input logic             wr_sel,
  input logic [W-1:0]     wr_data,
  input logic             irq_pulse,
  input logic [W-1:0]     cause_q,
  input logic [W-1:0]     mask_q,
  input logic             pend_q,
  input logic [DLY_W-1:0] cnt_q
);
  p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> ((cause_q & $past(evt_bits)) == $past(evt_bits)));

  p_no_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_byte && !wr_sel) |=> ((cause_q & $past(cause_q)) == $past(cause_q)));

  p_mask_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && wr_sel) |=> (mask_q == $past(wr_data)));

  p_byte_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && !wr_sel && !evt_valid) |=> (cause_q == {8'h00, $past(wr_data[7:0])}));

  p_word_status_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_byte && !wr_sel && !evt_valid) |=> $stable(cause_q));

  p_byte_mask_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_byte && wr_sel) |=> $stable(mask_q));

  p_floor_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !pend_q && !(wr_en && !wr_byte && wr_sel)) |=> !irq_pulse);

  p_due_fires_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q == DLY_W'(1)) |=> (irq_pulse && !pend_q));

  p_reload_shorter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cnt_q != DLY_W'(1) && evt_valid) |=> (pend_q && cnt_q < $past(cnt_q)));

  p_cnt_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (cnt_q != '0));
endmodule

bind intr_gate intr_gate_chk #(.W(W), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/intr_gate_tb.sv
`timescale 1ns/1ps
module intr_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [15:0] evt_bits = '0;
  logic [7:0]  evt_delay = '0;
  logic        wr_en = 1'b0, wr_byte = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        irq_level, irq_pulse;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_gate u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_bits(evt_bits),
    .evt_delay(evt_delay), .wr_en(wr_en), .wr_byte(wr_byte), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq_level(irq_level), .irq_pulse(irq_pulse));

  // Behavioural reference: absolute due time instead of a down-counter
  logic [15:0] m_cause, m_mask;
  bit          m_pend, m_pulse;
  longint      m_due, m_cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cause = '0; m_mask = '0; m_pend = 0; m_pulse = 0; m_due = 0; m_cyc = 0;
    end else begin
      bit fire, note;
      logic [15:0] nc;
      longint d;
      m_cyc++;
      fire = m_pend && (m_due == m_cyc);
      note = wr_en && !wr_byte && wr_sel && (wr_data != m_mask) &&
             (((m_mask | wr_data) & m_cause) != 0);
      nc = m_cause;
      if (wr_en && wr_byte && !wr_sel) nc = {8'h00, wr_data[7:0]};
      if (evt_valid) nc = nc | evt_bits;
      if (wr_en && !wr_byte && wr_sel) m_mask = wr_data;
      d = (evt_delay == 0) ? 1 : longint'(evt_delay);
      if (fire) m_pend = 0;
      else if (evt_valid) begin
        if (m_pend) m_due = (m_cyc + d < m_due) ? m_cyc + d : m_due;
        else begin m_pend = 1; m_due = m_cyc + d; end
      end
      m_pulse = fire || note;
      m_cause = nc;
    end
  end

  task automatic chk1(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    chk1(tag, "irq_level", irq_level, ((m_cause & m_mask) != 0));
    chk1(tag, "irq_pulse", irq_pulse, m_pulse);
    chk1(tag, "rd_data", rd_data, rd_sel ? m_mask : m_cause);
  endtask

  task automatic step(string tag, bit ev, logic [15:0] bits, logic [7:0] dly,
                      bit we, bit wb, bit ws, logic [15:0] wd, bit rs);
    evt_valid = ev; evt_bits = bits; evt_delay = dly;
    wr_en = we; wr_byte = wb; wr_sel = ws; wr_data = wd; rd_sel = rs;
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic idle(string tag, int n, bit rs);
    for (int i = 0; i < n; i++) step(tag, 0, 16'h0, 8'h0, 0, 0, 0, 16'h0, rs);
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired: actual running expected finished");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R8: reset state on both read selections
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    // R3: mask write with no causes pending gives no pulse
    step("R3", 0, 0, 0, 1, 0, 1, 16'h00F0, 1);
    // R5: delay 0 behaves as 1; R2 level follows immediately
    step("R5", 1, 16'h0010, 8'd0, 0, 0, 0, 0, 0);
    idle("R5", 3, 0);
    // R1: event adds bits, earlier bits stay; delay 3
    step("R1", 1, 16'h0100, 8'd3, 0, 0, 0, 0, 0);
    idle("R5", 5, 0);
    step("R2", 0, 0, 0, 1, 0, 1, 16'h0100, 1);
    // R4: byte write to status replaces cause, upper data bits dropped
    step("R4", 0, 0, 0, 1, 1, 0, 16'hFFA5, 0);
    step("R4", 1, 16'h0300, 8'd9, 1, 1, 0, 16'h7E11, 0);
    // R7: wrong-width writes ignored, observed through rd_data
    step("R7", 0, 0, 0, 1, 0, 0, 16'h1234, 0);
    step("R7", 0, 0, 0, 1, 1, 1, 16'h00FF, 1);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R5", 10, 1);
    // R3: same value, no pulse; new value covering old pending cause
    step("R3", 0, 0, 0, 1, 0, 1, 16'h0100, 1);
    step("R3", 0, 0, 0, 1, 0, 1, 16'h0000, 1);
    step("R3", 0, 0, 0, 1, 0, 1, 16'h0001, 1);
    step("R3", 0, 0, 0, 1, 0, 1, 16'h0010, 0);
    // R6: later event with shorter delay pulls delivery earlier
    step("R6", 1, 16'h0002, 8'd6, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 16'h0004, 8'd2, 0, 0, 0, 0, 0);
    idle("R6", 8, 0);
    // R6: event at the very edge the pending delivery is due
    step("R6", 1, 16'h0008, 8'd4, 0, 0, 0, 0, 0);
    idle("R6", 3, 0);
    step("R6", 1, 16'h0020, 8'd9, 0, 0, 0, 0, 0);
    idle("R6", 12, 0);
    // R9: mask notification coinciding with timed delivery
    step("R9", 1, 16'h0040, 8'd1, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 1, 0, 1, 16'hFFFF, 1);
    idle("R9", 3, 1);
    // R2: mixed random traffic
    for (int i = 0; i < 4000; i++) begin
      bit ev, we, wb, ws, rs;
      logic [15:0] b, wd;
      logic [7:0] dl;
      ev = ($urandom_range(0, 3) == 0);
      b  = 16'(1) << $urandom_range(0, 15);
      if ($urandom_range(0, 4) == 0) b = b | 16'($urandom);
      dl = ($urandom_range(0, 7) == 0) ? 8'($urandom_range(0, 40)) : 8'($urandom_range(0, 5));
      we = ($urandom_range(0, 4) == 0);
      wb = $urandom_range(0, 1);
      ws = $urandom_range(0, 1);
      wd = 16'($urandom);
      if ($urandom_range(0, 2) == 0) wd = m_mask;
      rs = $urandom_range(0, 1);
      step("R2", ev, b, dl, we, wb, ws, wd, rs);
    end
    idle("R5", 50, 0);
    finish_up();
  end
endmodule